// File: doc/BRIEF.md
# PCM Time-Slot Serial Port

This block is the digital side of a voice-channel codec's TDM link. An 8-bit transmit sample is shifted out most-significant bit first when the transmit frame sync is seen. While it is being shifted, an active-low slot strobe is driven and an output-enable marks the serial pin as driven, so an external 3-state buffer can share the line with other channels. The receive side samples eight serial bits on falling clock edges, starting at the receive frame sync. It delivers the assembled byte with a one-cycle valid pulse.

A law-select input picks A-law coding, in which the even bits are inverted, or µ-law coding, in which the byte passes unchanged. The choice applies in both directions. The block also watches its control inputs for inactivity. When both frame syncs stay low for a timeout, it flags standby. When the 2-bit gain code stays at zero for the same timeout, it flags power-down. A rate-select input scales the timeout to the chosen data-clock rate, and the timeout counts are parameters.

Top module: `pcm_tdm_port`

## Requirements
- R1: At the rising edge that samples `tx_sync` high, the slot starts. `tx_dout` shows coded bit 7 after that edge and coded bits 6 to 0 after the next seven rising edges, MSB first.
- R2: `slot_n` is low and `tx_doe` is high for exactly the eight bit times of a transmit slot. At all other times `slot_n` is high, `tx_doe` is low and `tx_dout` is 0.
- R3: At the falling edge that samples `rx_sync` high, `rx_din` is captured as bit 7. The next seven falling edges capture bits 6 to 0. After the eighth bit, `rx_data` holds the decoded byte and `rx_strobe` is high for exactly one clock cycle.
- R4: When `law_a`=1, the coding is XOR with 8'h55 on both transmit and receive. When `law_a`=0, the byte is unchanged.
- R5: A frame sync that arrives mid-slot restarts that direction's slot. On transmit, the new byte's bit 7 appears at once and the strobe stays low. On receive, no `rx_strobe` is produced for the aborted slot.
- R6: `standby` rises at the LIMIT-th consecutive rising edge that samples both syncs low. LIMIT depends on `rate_sel`: 2'b00 and 2'b11 select TO_2048, 2'b01 selects TO_1544, and 2'b10 selects TO_1536.
- R7: Any rising edge that samples either sync high clears the standby count, and `standby` is low after that edge.
- R8: `pwr_down` rises at the LIMIT-th consecutive rising edge that samples `gain_sel`==2'b00. Any edge that samples a nonzero code clears the count and `pwr_down`.
- R9: `gain_set` always equals `gain_sel`.
- R10: During reset, `slot_n`=1, `tx_doe`=0, `tx_dout`=0, `rx_strobe`=0, `standby`=0 and `pwr_down`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock; transmit on rising, receive on falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rate_sel | input | 2 | Data-clock rate choice, scales timeout |
| law_a | input | 1 | 1 = A-law coding, 0 = µ-law |
| gain_sel | input | 2 | Gain code; 00 held = power-down request |
| tx_sync | input | 1 | Transmit frame sync |
| tx_data | input | 8 | Transmit sample |
| tx_dout | output | 1 | Serial transmit data |
| tx_doe | output | 1 | Serial output enable |
| slot_n | output | 1 | Active-low transmit slot strobe |
| rx_sync | input | 1 | Receive frame sync |
| rx_din | input | 1 | Serial receive data |
| rx_data | output | 8 | Received, decoded byte |
| rx_strobe | output | 1 | One-cycle valid for rx_data |
| gain_set | output | 2 | Gain setting passed to both paths |
| standby | output | 1 | Both syncs idle for timeout |
| pwr_down | output | 1 | Gain code zero for timeout |

## Verification
The hardest case to reach from the ports is a receive slot aborted by a second sync, because it needs the sync and the serial data to be phased against the falling edge. The bench drives all inputs just after each rising edge. That puts every change half a cycle away from the falling edge that samples it. It can then inject a second receive sync after four bits and confirm that no valid pulse escapes before the restarted byte completes. The timeouts are shortened through parameters, so each rate code can be counted to the exact edge.

// File: rtl/pcm_tdm_port.sv
module pcm_tdm_port #(
  parameter int TO_2048 = 614400,
  parameter int TO_1544 = 463200,
  parameter int TO_1536 = 460800
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rate_sel,
  input  logic       law_a,
  input  logic [1:0] gain_sel,
  input  logic       tx_sync,
  input  logic [7:0] tx_data,
  output logic       tx_dout,
  output logic       tx_doe,
  output logic       slot_n,
  input  logic       rx_sync,
  input  logic       rx_din,
  output logic [7:0] rx_data,
  output logic       rx_strobe,
  output logic [1:0] gain_set,
  output logic       standby,
  output logic       pwr_down
);
  localparam int TOM1 = (TO_2048 > TO_1544) ? TO_2048 : TO_1544;
  localparam int TOMAX = (TOM1 > TO_1536) ? TOM1 : TO_1536;
  localparam int CW = $clog2(TOMAX + 1);

  logic [7:0] mask;
  logic [7:0] tx_sh, rx_sh;
  logic [2:0] tx_cnt, rx_cnt;
  logic tx_act, rx_act;
  logic [CW-1:0] lim, sb_cnt, pd_cnt;

  assign mask = law_a ? 8'h55 : 8'h00;
  assign tx_dout = tx_act & tx_sh[7];
  assign tx_doe = tx_act;
  assign slot_n = ~tx_act;
  assign gain_set = gain_sel;

  always_comb
    case (rate_sel)
      2'd1:    lim = CW'(TO_1544);
      2'd2:    lim = CW'(TO_1536);
      default: lim = CW'(TO_2048);
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_act <= 1'b0;
      tx_cnt <= '0;
      tx_sh  <= '0;
    end else if (tx_sync) begin
      tx_act <= 1'b1;
      tx_cnt <= '0;
      tx_sh  <= tx_data ^ mask;
    end else if (tx_act) begin
      if (tx_cnt == 3'd7) tx_act <= 1'b0;
      tx_cnt <= tx_cnt + 3'd1;
      tx_sh  <= {tx_sh[6:0], 1'b0};
    end

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_act    <= 1'b0;
      rx_cnt    <= '0;
      rx_sh     <= '0;
      rx_data   <= '0;
      rx_strobe <= 1'b0;
    end else begin
      rx_strobe <= 1'b0;
      if (rx_sync) begin
        rx_act <= 1'b1;
        rx_cnt <= 3'd1;
        rx_sh  <= {7'd0, rx_din};
      end else if (rx_act) begin
        rx_sh  <= {rx_sh[6:0], rx_din};
        rx_cnt <= rx_cnt + 3'd1;
        if (rx_cnt == 3'd7) begin
          rx_act    <= 1'b0;
          rx_data   <= {rx_sh[6:0], rx_din} ^ mask;
          rx_strobe <= 1'b1;
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sb_cnt  <= '0;
      standby <= 1'b0;
    end else if (tx_sync | rx_sync) begin
      sb_cnt  <= '0;
      standby <= 1'b0;
    end else if (!standby) begin
      if (sb_cnt >= lim - CW'(1)) standby <= 1'b1;
      else sb_cnt <= sb_cnt + CW'(1);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pd_cnt   <= '0;
      pwr_down <= 1'b0;
    end else if (gain_sel != 2'b00) begin
      pd_cnt   <= '0;
      pwr_down <= 1'b0;
    end else if (!pwr_down) begin
      if (pd_cnt >= lim - CW'(1)) pwr_down <= 1'b1;
      else pd_cnt <= pd_cnt + CW'(1);
    end
endmodule

module pcm_tdm_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] gain_sel,
  input logic       tx_sync,
  input logic       rx_sync,
  input logic       tx_doe,
  input logic       tx_dout,
  input logic       rx_strobe,
  input logic       standby,
  input logic       pwr_down
);
  logic [3:0] run;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) run <= '0;
    else if (tx_sync) run <= 4'd1;
    else if (tx_doe && run < 4'd15) run <= run + 4'd1;
    else if (!tx_doe) run <= '0;

  a_r1_slot_start: assert property (@(posedge clk) disable iff (!rst_n) tx_sync |=> tx_doe);
  a_r2_slot_len:   assert property (@(posedge clk) disable iff (!rst_n) tx_doe |-> run <= 4'd8);
  a_r2_idle_zero:  assert property (@(negedge clk) disable iff (!rst_n) !tx_doe |-> !tx_dout);
  a_r3_one_pulse:  assert property (@(negedge clk) disable iff (!rst_n) rx_strobe |=> !rx_strobe);
  a_r6_needs_idle: assert property (@(posedge clk) disable iff (!rst_n) $rose(standby) |-> $past(!tx_sync && !rx_sync));
  a_r7_wake:       assert property (@(posedge clk) disable iff (!rst_n) (tx_sync || rx_sync) |=> !standby);
  a_r8_wake:       assert property (@(posedge clk) disable iff (!rst_n) (gain_sel != 2'b00) |=> !pwr_down);
endmodule

bind pcm_tdm_port pcm_tdm_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .gain_sel(gain_sel), .tx_sync(tx_sync), .rx_sync(rx_sync),
  .tx_doe(tx_doe), .tx_dout(tx_dout), .rx_strobe(rx_strobe), .standby(standby), .pwr_down(pwr_down)
);

// File: tb/pcm_tdm_port_tb.sv
module pcm_tdm_port_tb;
  localparam int L0 = 20, L1 = 15, L2 = 12;
  logic clk = 0, rst_n = 0;
  logic [1:0] rate_sel = 0, gain_sel = 2'b01;
  logic law_a = 0, tx_sync = 0, rx_sync = 0, rx_din = 0;
  logic [7:0] tx_data = 0;
  logic tx_dout, tx_doe, slot_n, rx_strobe, standby, pwr_down;
  logic [7:0] rx_data;
  logic [1:0] gain_set;
  int checks = 0, errors = 0;
  bit done = 0;

  pcm_tdm_port #(.TO_2048(L0), .TO_1544(L1), .TO_1536(L2)) u_dut (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .law_a(law_a), .gain_sel(gain_sel),
    .tx_sync(tx_sync), .tx_data(tx_data), .tx_dout(tx_dout), .tx_doe(tx_doe), .slot_n(slot_n),
    .rx_sync(rx_sync), .rx_din(rx_din), .rx_data(rx_data), .rx_strobe(rx_strobe),
    .gain_set(gain_set), .standby(standby), .pwr_down(pwr_down));

  always #2.5 clk = ~clk;

  localparam logic [16:0] VEC [6] = '{
    {1'b0, 8'hA5, 8'h3C}, {1'b1, 8'hA5, 8'h3C}, {1'b0, 8'h00, 8'hFF},
    {1'b1, 8'hFF, 8'h00}, {1'b0, 8'h81, 8'h7E}, {1'b1, 8'h5A, 8'hC3}};

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step;
    @(posedge clk); #1;
  endtask

  function automatic logic [7:0] code(logic a, logic [7:0] b);
    return a ? (b ^ 8'h55) : b;
  endfunction

  task automatic standby_run(logic [1:0] sel, int lim);
    rate_sel = sel; tx_sync = 1; rx_sync = 0;
    step; tx_sync = 0;
    repeat (lim - 1) step;
    chk("R6 before limit", {7'd0, standby}, 8'd0);
    step;
    chk("R6 at limit", {7'd0, standby}, 8'd1);
    rx_sync = 1; step; rx_sync = 0;
    chk("R7 wake", {7'd0, standby}, 8'd0);
    repeat (10) step;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #7;
    chk("R10 slot_n", {7'd0, slot_n}, 8'd1);
    chk("R10 doe/dout", {6'd0, tx_doe, tx_dout}, 8'd0);
    chk("R10 strobe/standby/pd", {5'd0, rx_strobe, standby, pwr_down}, 8'd0);
    rst_n = 1;
    step;

    foreach (VEC[v]) begin
      logic [7:0] et, rb, got;
      law_a = VEC[v][16]; tx_data = VEC[v][15:8]; rb = VEC[v][7:0];
      et = code(law_a, tx_data);
      tx_sync = 1; rx_sync = 1; rx_din = rb[7];
      got = 0;
      for (int k = 1; k <= 8; k++) begin
        step;
        tx_sync = 0; rx_sync = 0;
        if (k <= 7) rx_din = rb[7-k];
        got = {got[6:0], tx_dout};
        chk("R2 strobe low in slot", {6'd0, slot_n, tx_doe}, 8'd1);
        if (k < 8) chk("R3 no early strobe", {7'd0, rx_strobe}, 8'd0);
      end
      chk("R1 R4 serial byte", got, et);
      chk("R3 strobe", {7'd0, rx_strobe}, 8'd1);
      chk("R3 R4 rx byte", rx_data, code(law_a, rb));
      step;
      chk("R2 slot end", {5'd0, slot_n, tx_doe, tx_dout}, 8'h04);
      chk("R3 single pulse", {7'd0, rx_strobe}, 8'd0);
      step;
    end

    begin
      logic [7:0] ob, nb, got;
      law_a = 0; ob = 8'hF0; nb = 8'h96;
      tx_data = 8'h0F; tx_sync = 1; rx_sync = 1; rx_din = ob[7];
      for (int k = 1; k <= 3; k++) begin
        step; tx_sync = 0; rx_sync = 0; rx_din = ob[7-k];
      end
      step;
      tx_data = 8'hC3; tx_sync = 1; rx_sync = 1; rx_din = nb[7];
      got = 0;
      for (int k = 1; k <= 8; k++) begin
        step;
        tx_sync = 0; rx_sync = 0;
        if (k <= 7) rx_din = nb[7-k];
        got = {got[6:0], tx_dout};
        chk("R5 strobe held", {7'd0, slot_n}, 8'd0);
        if (k < 8) chk("R5 no byte for aborted slot", {7'd0, rx_strobe}, 8'd0);
      end
      chk("R5 tx restarted byte", got, 8'hC3);
      chk("R5 rx restarted byte", rx_data, nb);
      chk("R5 strobe after restart", {7'd0, rx_strobe}, 8'd1);
      step;
    end

    standby_run(2'd1, L1);
    standby_run(2'd2, L2);
    standby_run(2'd0, L0);
    standby_run(2'd3, L0);

    rate_sel = 2'd2; gain_sel = 2'b01; step;
    chk("R9 gain pass", {6'd0, gain_set}, 8'd1);
    gain_sel = 2'b00;
    repeat (L2 - 1) step;
    chk("R8 before limit", {7'd0, pwr_down}, 8'd0);
    step;
    chk("R8 at limit", {7'd0, pwr_down}, 8'd1);
    chk("R9 gain zero", {6'd0, gain_set}, 8'd0);
    gain_sel = 2'b10; step;
    chk("R8 wake", {7'd0, pwr_down}, 8'd0);
    chk("R9 gain two", {6'd0, gain_set}, 8'd2);

    rst_n = 0; #1;
    chk("R10 reset mid-run", {4'd0, slot_n, tx_doe, rx_strobe, standby}, 8'h08);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule